// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the status byte of a serial nonvolatile memory and makes every decision on whether a write may go ahead. It holds the write-enable latch, the busy flag of the internal write cycle, the status-write-lock bit and the two block-protect bits. It also samples a hardware protect pin, which is active low. The command decoder sits beside it and sends single-cycle strobes for the enable and disable commands and for status-write and array-write requests. In return it gets two combinational permissions and the status byte that is returned on a status read.

An accepted write starts a timed internal cycle of `WRITE_CYCLES` clocks and clears the write-enable latch. A write to the status byte only loads a shadow copy. The lock and protect bits that can be read keep their old values until the cycle ends. While the cycle runs, the guard grants nothing and ignores every command. A request that is refused for lack of permission starts no cycle. By default a refused request also drops the write-enable latch.

Top module: `status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 (no lock, no protected area, latch clear, not busy), and both permissions are low.
- R2: An enable strobe sets the write-enable latch (status bit 1) and a disable strobe clears it. When both arrive in the same cycle, the latch ends up clear.
- R3: The status byte is laid out as bit 7 = lock, bits 6..4 = 0, bits 3..2 = protect level, bit 1 = write-enable latch, bit 0 = busy. A status write takes only bits 7, 3 and 2 of its data byte.
- R4: A status write is permitted only when the latch is set, no cycle is running, and the status is not in the state where lock = 1 and the protect pin is low. When lock = 0, the pin level does not matter.
- R5: The hardware-locked state is reached whether the pin falls before or after lock is set, and raising the pin ends it.
- R6: Protect level 00 guards nothing. Level 01 guards the top quarter of the array (the two upper address bits are 11). Level 10 guards the top half (upper address bit is 1). Level 11 guards the whole array. An array write is permitted only when the latch is set, no cycle is running and the address is not guarded.
- R7: An accepted write sets busy for exactly `WRITE_CYCLES` clocks, beginning at the clock edge that takes the request, and clears the latch.
- R8: While busy is set, status bits 7..2 keep their values from before the cycle. A new lock and protect value becomes visible in the same cycle that busy falls.
- R9: A refused request made while not busy leaves busy at 0 and, with `CLR_WEL_ON_REJECT` = 1 (the default), clears the latch.
- R10: While busy is set, both permissions are low, and enable, disable and write requests change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, standing in for power-on |
| cmdSetWel | input | 1 | Enable-command strobe |
| cmdClrWel | input | 1 | Disable-command strobe |
| srWrReq | input | 1 | Status-write request strobe |
| srWrData | input | 8 | Byte offered for the status write |
| arWrReq | input | 1 | Array-write request strobe |
| arWrAddr | input | ADDR_W | Array address being queried or written |
| wrProtN | input | 1 | Hardware protect pin, low = protect |
| srWrAllow | output | 1 | A status write would be accepted now |
| arWrAllow | output | 1 | A write to arWrAddr would be accepted now |
| statusByte | output | 8 | Status byte for reads |

## Verification
Two things can land in the same cycle: a command strobe and a running write cycle, or an enable strobe and a disable strobe. The bench raises an enable strobe in the first busy cycle of a status write. It then checks that the latch bit stays clear and that the lock and protect bits still show their old values until busy falls. It also counts how many cycles busy stays high. Separately, the bench drives enable and disable together and checks that the latch reads clear.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;
  typedef struct packed {
    logic welSet;
    logic welClr;
    logic wipSet;
    logic wipClr;
    logic latchNv;
    logic commitNv;
  } guardStrobes_t;
endpackage

// File: rtl/status_permit.sv
module status_permit
  import status_guard_pkg::*;
#(
  parameter int ADDR_W            = 13,
  parameter int WRITE_CYCLES      = 8,
  parameter bit CLR_WEL_ON_REJECT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSetWel,
  input  logic              cmdClrWel,
  input  logic              srWrReq,
  input  logic              arWrReq,
  input  logic [ADDR_W-1:0] arWrAddr,
  input  logic              wrProtN,
  input  logic              wel,
  input  logic              wip,
  input  logic              srwd,
  input  logic [1:0]        bp,
  output guardStrobes_t     strobes,
  output logic              srWrAllow,
  output logic              arWrAllow
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);

  logic [CNT_W-1:0] cycLeft;
  logic guarded, srAcc, arAcc, reject, hwLocked;

  always_comb begin
    unique case (bp)
      2'b00: guarded = 1'b0;
      2'b01: guarded = (arWrAddr >= QUARTER_BASE);
      2'b10: guarded = (arWrAddr >= HALF_BASE);
      default: guarded = 1'b1;
    endcase
  end

  assign hwLocked  = srwd && !wrProtN;
  assign srWrAllow = wel && !wip && !hwLocked;
  assign arWrAllow = wel && !wip && !guarded;

  assign srAcc  = srWrReq && srWrAllow;
  assign arAcc  = arWrReq && arWrAllow;
  assign reject = !wip && ((srWrReq && !srWrAllow) || (arWrReq && !arWrAllow));

  always_comb begin
    strobes          = '0;
    strobes.wipSet   = srAcc || arAcc;
    strobes.latchNv  = srAcc;
    strobes.welSet   = !wip && cmdSetWel;
    strobes.welClr   = !wip && (cmdClrWel || srAcc || arAcc ||
                                (reject && CLR_WEL_ON_REJECT));
    strobes.wipClr   = wip && (cycLeft == '0);
    strobes.commitNv = wip && (cycLeft == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cycLeft <= '0;
    else if (strobes.wipSet)         cycLeft <= CNT_W'(WRITE_CYCLES - 1);
    else if (wip && cycLeft != '0)   cycLeft <= cycLeft - 1'b1;
  end
endmodule

// File: rtl/status_store.sv
module status_store
  import status_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  input  logic [7:0]    srWrData,
  output logic          wel,
  output logic          wip,
  output logic          srwd,
  output logic [1:0]    bp,
  output logic [7:0]    statusByte
);
  logic       pendNv;
  logic       shadowSrwd;
  logic [1:0] shadowBp;
  logic       unusedBits;

  assign unusedBits = ^{srWrData[6:4], srWrData[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel        <= 1'b0;
      wip        <= 1'b0;
      srwd       <= 1'b0;
      bp         <= 2'b00;
      pendNv     <= 1'b0;
      shadowSrwd <= 1'b0;
      shadowBp   <= 2'b00;
    end else begin
      if (strobes.welClr)      wel <= 1'b0;
      else if (strobes.welSet) wel <= 1'b1;

      if (strobes.wipSet)      wip <= 1'b1;
      else if (strobes.wipClr) wip <= 1'b0;

      if (strobes.latchNv) begin
        shadowSrwd <= srWrData[7];
        shadowBp   <= srWrData[3:2];
        pendNv     <= 1'b1;
      end else if (strobes.commitNv && pendNv) begin
        srwd   <= shadowSrwd;
        bp     <= shadowBp;
        pendNv <= 1'b0;
      end
    end
  end

  assign statusByte = {srwd, 3'b000, bp, wel, wip};
endmodule

// File: rtl/status_guard.sv
module status_guard
  import status_guard_pkg::*;
#(
  parameter int ADDR_W            = 13,
  parameter int WRITE_CYCLES      = 8,
  parameter bit CLR_WEL_ON_REJECT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSetWel,
  input  logic              cmdClrWel,
  input  logic              srWrReq,
  input  logic [7:0]        srWrData,
  input  logic              arWrReq,
  input  logic [ADDR_W-1:0] arWrAddr,
  input  logic              wrProtN,
  output logic              srWrAllow,
  output logic              arWrAllow,
  output logic [7:0]        statusByte
);
  guardStrobes_t strobes;
  logic wel, wip, srwd;
  logic [1:0] bp;

  status_permit #(
    .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .CLR_WEL_ON_REJECT(CLR_WEL_ON_REJECT)
  ) permit_i (
    .clk(clk), .rstN(rstN), .cmdSetWel(cmdSetWel), .cmdClrWel(cmdClrWel),
    .srWrReq(srWrReq), .arWrReq(arWrReq), .arWrAddr(arWrAddr), .wrProtN(wrProtN),
    .wel(wel), .wip(wip), .srwd(srwd), .bp(bp),
    .strobes(strobes), .srWrAllow(srWrAllow), .arWrAllow(arWrAllow)
  );

  status_store store_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srWrData(srWrData),
    .wel(wel), .wip(wip), .srwd(srwd), .bp(bp), .statusByte(statusByte)
  );
endmodule

// File: rtl/status_guard_chk.sv
module status_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdSetWel,
  input logic       cmdClrWel,
  input logic       srWrReq,
  input logic       arWrReq,
  input logic       wrProtN,
  input logic       srWrAllow,
  input logic       arWrAllow,
  input logic [7:0] statusByte
);
  AST_WIP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (srWrReq && srWrAllow) || (arWrReq && arWrAllow) |=> statusByte[0]); // R7
  AST_WEL_DROP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (srWrReq && srWrAllow) || (arWrReq && arWrAllow) |=> !statusByte[1]); // R7
  AST_HW_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] && !wrProtN |-> !srWrAllow); // R4
  AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] |-> !srWrAllow && !arWrAllow); // R10
  AST_NV_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusByte[0]) && statusByte[0] |-> $stable(statusByte[7:2])); // R8
  AST_REJECT_NO_WIP: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[0] && srWrReq && !srWrAllow && !arWrReq |=> !statusByte[0]); // R9
  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    cmdSetWel && !cmdClrWel && !srWrReq && !arWrReq && !statusByte[0]
      |=> statusByte[1]); // R2
endmodule

bind status_guard status_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdSetWel(cmdSetWel), .cmdClrWel(cmdClrWel),
  .srWrReq(srWrReq), .arWrReq(arWrReq), .wrProtN(wrProtN),
  .srWrAllow(srWrAllow), .arWrAllow(arWrAllow), .statusByte(statusByte)
);

// File: tb/status_guard_tb_top.sv
module status_guard_tb_top;
  localparam int AW = 13;
  localparam int WC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdSetWel = 0, cmdClrWel = 0, srWrReq = 0, arWrReq = 0;
  logic [7:0] srWrData = '0;
  logic [AW-1:0] arWrAddr = '0;
  logic wrProtN = 1'b1;
  logic srWrAllow, arWrAllow;
  logic [7:0] statusByte;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  status_guard #(.ADDR_W(AW), .WRITE_CYCLES(WC), .CLR_WEL_ON_REJECT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .cmdSetWel(cmdSetWel), .cmdClrWel(cmdClrWel),
    .srWrReq(srWrReq), .srWrData(srWrData), .arWrReq(arWrReq), .arWrAddr(arWrAddr),
    .wrProtN(wrProtN), .srWrAllow(srWrAllow), .arWrAllow(arWrAllow),
    .statusByte(statusByte)
  );

  // op: 0 enable, 1 disable, 2 status write, 3 array write
  // {op[2], data[8], addr[13], pin[1], expAllow[1], expStatus[8]}
  localparam int NV = 29;
  localparam logic [32:0] VEC [NV] = '{
    {2'd2, 8'h0C, 13'h0000, 1'b1, 1'b0, 8'h00},  // R4 R9 no latch
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h02},  // R2
    {2'd1, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h00},  // R2
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h02},
    {2'd2, 8'h04, 13'h0000, 1'b1, 1'b1, 8'h04},  // R4 R7 level 01
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h06},
    {2'd3, 8'h00, 13'h1800, 1'b1, 1'b0, 8'h04},  // R6 R9 top quarter
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h06},
    {2'd3, 8'h00, 13'h17FF, 1'b1, 1'b1, 8'h04},  // R6 below quarter
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h06},
    {2'd2, 8'h88, 13'h0000, 1'b1, 1'b1, 8'h88},  // R3 lock + level 10
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h8A},
    {2'd3, 8'h00, 13'h1000, 1'b1, 1'b0, 8'h88},  // R6 top half
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h8A},
    {2'd3, 8'h00, 13'h0FFF, 1'b1, 1'b1, 8'h88},  // R6 below half
    {2'd0, 8'h00, 13'h0000, 1'b0, 1'b0, 8'h8A},
    {2'd2, 8'h00, 13'h0000, 1'b0, 1'b0, 8'h88},  // R5 pin after lock
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h8A},
    {2'd2, 8'h0C, 13'h0000, 1'b1, 1'b1, 8'h0C},  // R5 pin raised
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h0E},
    {2'd3, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h0C},  // R6 level 11
    {2'd0, 8'h00, 13'h0000, 1'b0, 1'b0, 8'h0E},
    {2'd2, 8'h70, 13'h0000, 1'b0, 1'b1, 8'h00},  // R3 R4 unlocked, pin low
    {2'd0, 8'h00, 13'h0000, 1'b0, 1'b0, 8'h02},
    {2'd2, 8'h80, 13'h0000, 1'b0, 1'b1, 8'h80},  // R5 lock after pin
    {2'd0, 8'h00, 13'h0000, 1'b0, 1'b0, 8'h82},
    {2'd2, 8'h00, 13'h0000, 1'b0, 1'b0, 8'h80},  // R5 locked
    {2'd0, 8'h00, 13'h0000, 1'b1, 1'b0, 8'h82},
    {2'd2, 8'h00, 13'h0000, 1'b1, 1'b1, 8'h00}   // R5 pin high ends lock
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int g = 0; g < 100 && statusByte[0]; g++) @(negedge clk);
  endtask

  task automatic doOp(input logic [1:0] op, input logic [7:0] data,
                      input logic [AW-1:0] addr, input logic pin, output logic allow);
    @(negedge clk);
    wrProtN  = pin;
    srWrData = data;
    arWrAddr = addr;
    cmdSetWel = (op == 2'd0);
    cmdClrWel = (op == 2'd1);
    srWrReq   = (op == 2'd2);
    arWrReq   = (op == 2'd3);
    #1;
    allow = (op == 2'd2) ? srWrAllow : arWrAllow;
    @(negedge clk);
    cmdSetWel = 0; cmdClrWel = 0; srWrReq = 0; arWrReq = 0;
    waitIdle();
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic a;
    int busyCnt;
    repeat (3) @(negedge clk);
    check("R1 reset status", statusByte, 8'h00);
    check("R1 reset permissions", {6'd0, srWrAllow, arWrAllow}, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doOp(VEC[i][32:31], VEC[i][30:23], VEC[i][22:10], VEC[i][9], a);
      if (VEC[i][32]) check($sformatf("R4/R6 vector %0d permission", i), {7'd0, a}, {7'd0, VEC[i][8]});
      check($sformatf("R3/R7 vector %0d status", i), statusByte, VEC[i][7:0]);
    end

    // R2: enable and disable in the same cycle -> latch clear
    doOp(2'd0, 8'h00, '0, 1'b1, a);
    @(negedge clk); cmdSetWel = 1; cmdClrWel = 1;
    @(negedge clk); cmdSetWel = 0; cmdClrWel = 0;
    check("R2 set+clear collision", statusByte, 8'h00);

    // R7 R8 R10: frozen bits, ignored command while busy, busy length
    doOp(2'd0, 8'h00, '0, 1'b1, a);
    @(negedge clk); srWrData = 8'h8C; srWrReq = 1;
    @(negedge clk); srWrReq = 0;
    check("R8 old bits during write", statusByte, 8'h01);
    check("R10 no grant while busy", {6'd0, srWrAllow, arWrAllow}, 8'h00);
    busyCnt = 1;
    cmdSetWel = 1; arWrReq = 1; arWrAddr = '0;
    @(negedge clk); cmdSetWel = 0; arWrReq = 0;
    check("R10 enable ignored while busy", statusByte, 8'h01);
    for (int g = 0; g < 100 && statusByte[0]; g++) begin
      busyCnt++;
      @(negedge clk);
    end
    check("R7 busy length", 8'(busyCnt), 8'(WC));
    check("R8 new bits after write", statusByte, 8'h8C);

    // R1: reset in the middle of a write
    doOp(2'd0, 8'h00, '0, 1'b1, a);
    @(negedge clk); srWrData = 8'h00; srWrReq = 1;
    @(negedge clk); srWrReq = 0;
    @(negedge clk); rstN = 0;
    @(negedge clk);
    check("R1 reset mid-write", statusByte, 8'h00);
    rstN = 1;
    @(negedge clk);
    check("R1 idle after reset", statusByte, 8'h00);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule